// File: doc/BRIEF.md
# Pulse-Width Single-Wire Bus Master

This block runs whole frames on a single open-drain wire where each bit is told apart by how long the line stays low. The length of the low phase is one, three or six time units, and every symbol fills a fixed slot of nine units. The time unit is a parameter counted in clock cycles. On a start request the master first drives a run of short sync pulses as a pause. It then drives a direction bit of zero, a 3-bit slave address, a 4-bit register address and a parity bit that covers those eight bits.

Bit 3 of the register address selects the kind of access. On a write the master goes on to drive the data byte and its parity bit. It then gives the wire to the slave for the acknowledge. On a read the master only issues a one-unit start pulse in each remaining slot, and the slave stretches that pulse to send the data byte, its parity and the acknowledge.

For every slave-driven slot the master counts how many cycles the line was low and sorts the count against midpoint thresholds. The result of the frame comes back through a busy/done handshake, together with the read byte, a parity-error flag and an acknowledge-failure flag.

Top module: `pwm_bus_master`

## Requirements
- R1: In every slot the master pulls the line low from the first cycle of the slot. It pulls for UNIT_CLKS cycles for a sync or a start pulse, 3*UNIT_CLKS cycles for a 0 and 6*UNIT_CLKS cycles for a 1, and then releases the line for the rest of the 9*UNIT_CLKS-cycle slot.
- R2: A frame is PAUSE_SYNCS sync slots followed by 19 bit slots. The order of the bit slots is: direction (always 0), slave address (most significant bit first), register address (MSB first), first parity, data byte (MSB first), second parity, acknowledge.
- R3: The first parity is the XOR of the direction bit, the address bits and the register bits. On a write the second parity is the XOR of the eight data bits.
- R4: reg_addr[3] = 1 selects a write, where only the acknowledge slot is slave-driven. reg_addr[3] = 0 selects a read, where the data, second-parity and acknowledge slots are slave-driven. In a slave-driven slot the master only drives a one-unit start pulse.
- R5: A slave-driven slot is sorted by the total number of low cycles L within the slot. L < 2*UNIT_CLKS is a sync, 2*L > 9*UNIT_CLKS is a 1, and anything else is a 0. A received data bit is 1 only for the 1 class.
- R6: At the end of a read, rdata holds the eight received data bits (first received bit in bit 7). parity_err is 1 when the XOR of those bits and the received second parity is 1. A write clears parity_err and leaves rdata unchanged.
- R7: ack_fail is 0 only when the acknowledge slot is sorted as a 0. A sync or a 1 sets it.
- R8: A start seen while idle sets busy on the next cycle, and the first low phase begins in that same cycle. busy falls and done pulses for exactly one cycle right after the last cycle of the acknowledge slot.
- R9: A start seen while busy is ignored, and the frame in progress is unchanged.
- R10: After reset busy, done, line_pull, rdata, parity_err and ack_fail are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a frame (taken only when idle) |
| slave_addr | input | 3 | Target slave address |
| reg_addr | input | 4 | Register address; bit 3 = 1 selects a write |
| wdata | input | 8 | Byte to write |
| line_in | input | 1 | Sensed level of the bus wire (0 = low) |
| line_pull | output | 1 | 1 enables the open-drain pull-down |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| rdata | output | 8 | Byte received on the last read |
| parity_err | output | 1 | Second parity mismatch on the last read |
| ack_fail | output | 1 | Acknowledge not received as 0 on the last frame |

## Verification
The assertions expect start to be a level that the block samples only while idle, and line_in to be the wired-AND of the block's own pull and one slave. Anything else on the wire, or a slave that holds the line past its slot, would break the slot counting. The bench drives the slave only inside slave-driven slots, starting two cycles into the master's start pulse and never beyond the slot end. Its pulse lengths are chosen on each side of both thresholds, including exactly 4.5 units and one cycle below 2 units.

// File: rtl/pwm_bus_master.sv
module pwm_bus_master #(
  parameter int UNIT_CLKS   = 8,
  parameter int PAUSE_SYNCS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] slave_addr,
  input  logic [3:0] reg_addr,
  input  logic [7:0] wdata,
  input  logic       line_in,
  output logic       line_pull,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdata,
  output logic       parity_err,
  output logic       ack_fail
);
  localparam int SLOT = 9 * UNIT_CLKS;
  localparam int NSYM = PAUSE_SYNCS + 19;
  localparam int CW   = $clog2(SLOT + 1);
  localparam int IW   = $clog2(NSYM + 1);
  localparam logic [CW-1:0] LEN_S  = CW'(UNIT_CLKS);
  localparam logic [CW-1:0] LEN_0  = CW'(3 * UNIT_CLKS);
  localparam logic [CW-1:0] LEN_1  = CW'(6 * UNIT_CLKS);
  localparam logic [CW-1:0] TH_LO  = CW'(2 * UNIT_CLKS);
  localparam logic [CW-1:0] TH_HI  = CW'((9 * UNIT_CLKS) / 2);
  localparam logic [CW-1:0] CNT_END = CW'(SLOT - 1);
  localparam logic [IW-1:0] IDX_RD  = IW'(PAUSE_SYNCS + 9);
  localparam logic [IW-1:0] IDX_ACK = IW'(NSYM - 1);
  localparam logic [IW-1:0] IDX_P   = IW'(PAUSE_SYNCS);

  logic [CW-1:0] cnt, lowcnt, meas, low_len;
  logic [IW-1:0] idx;
  logic [18:0]   tx;
  logic [8:0]    rx;
  logic          is_rd;

  wire in_pause  = idx < IDX_P;
  wire ack_slot  = idx == IDX_ACK;
  wire slv_slot  = !in_pause && (ack_slot || (is_rd && idx >= IDX_RD));
  wire slot_end  = busy && cnt == CNT_END;
  wire p1        = ^{1'b0, slave_addr, reg_addr};

  assign low_len   = (in_pause || slv_slot) ? LEN_S : (tx[18] ? LEN_1 : LEN_0);
  assign line_pull = busy && (cnt < low_len);
  assign meas      = lowcnt + CW'(!line_in);

  wire got_one  = meas > TH_HI;
  wire got_zero = !got_one && meas >= TH_LO;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      cnt        <= '0;
      lowcnt     <= '0;
      idx        <= '0;
      tx         <= '0;
      rx         <= '0;
      is_rd      <= 1'b0;
      rdata      <= '0;
      parity_err <= 1'b0;
      ack_fail   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          cnt    <= '0;
          lowcnt <= '0;
          idx    <= '0;
          is_rd  <= !reg_addr[3];
          tx     <= {1'b0, slave_addr, reg_addr, p1, wdata, ^wdata, 1'b0};
        end
      end else begin
        cnt    <= slot_end ? '0 : cnt + 1'b1;
        lowcnt <= slot_end ? '0 : meas;
        if (slot_end) begin
          idx <= idx + 1'b1;
          if (!in_pause) tx <= {tx[17:0], 1'b0};
          if (slv_slot && !ack_slot) rx <= {rx[7:0], got_one};
          if (ack_slot) begin
            busy       <= 1'b0;
            done       <= 1'b1;
            ack_fail   <= !got_zero;
            parity_err <= is_rd && (^rx);
            if (is_rd) rdata <= rx[8:1];
          end
        end
      end
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_end_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_pull);
  assert_start_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && line_pull));
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !slot_end) |=> $stable(idx));
  assert_write_no_perr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_rd) |-> !parity_err);
endmodule

// File: tb/pwm_bus_master_test.sv
module pwm_bus_master_test;
  localparam int U = 4;
  localparam int P = 3;
  localparam int SLOT = 9 * U;
  localparam int NSYM = P + 19;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, slave_pull = 1'b0;
  logic [2:0] slave_addr = '0;
  logic [3:0] reg_addr = '0;
  logic [7:0] wdata = '0;
  logic line_pull, busy, done, parity_err, ack_fail;
  logic [7:0] rdata;
  wire line_in = !(line_pull || slave_pull);

  int total = 0, bad = 0;
  int slv[11];
  logic [7:0] last_rdata = '0;

  always #2 clk = !clk;

  pwm_bus_master #(.UNIT_CLKS(U), .PAUSE_SYNCS(P)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .slave_addr(slave_addr),
    .reg_addr(reg_addr), .wdata(wdata), .line_in(line_in), .line_pull(line_pull),
    .busy(busy), .done(done), .rdata(rdata), .parity_err(parity_err), .ack_fail(ack_fail));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int klass(input int len);
    int low = (len > U) ? len : U;
    if (2 * low > 9 * U) return 2;
    if (low >= 2 * U) return 1;
    return 0;
  endfunction

  task automatic set_byte(input logic [7:0] b, input bit p2, input int acklen);
    for (int i = 0; i < 8; i++) slv[i] = b[7-i] ? 6 * U : 3 * U;
    slv[8] = p2 ? 6 * U : 3 * U;
    slv[10] = acklen;
  endtask

  task automatic run_frame(input logic [2:0] sa, input logic [3:0] ra,
                           input logic [7:0] wd, input bit poke, input string tag);
    bit q[$];
    bit rd = !ra[3];
    int ones = 0, mism = 0, bad_s = -1, bad_c = -1, bad_a = 0, bad_e = 0;
    logic [7:0] exp_rd = '0;
    bit exp_p2 = 0;
    q.push_back(1'b0);
    for (int i = 2; i >= 0; i--) q.push_back(sa[i]);
    for (int i = 3; i >= 0; i--) q.push_back(ra[i]);
    foreach (q[i]) ones += q[i];
    q.push_back(ones % 2 == 1);
    ones = 0;
    for (int i = 7; i >= 0; i--) begin q.push_back(wd[i]); ones += wd[i]; end
    q.push_back(ones % 2 == 1);
    @(negedge clk);
    slave_addr = sa; reg_addr = ra; wdata = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < NSYM; s++) begin
      for (int c = 0; c < SLOT; c++) begin
        bit sv = (s >= P) && ((s == NSYM - 1) || (rd && s >= P + 9));
        int len = (s < P || sv) ? U : (q[s-P] ? 6 * U : 3 * U);
        int slen = 0;
        if (line_pull !== (c < len) || busy !== 1'b1 || done !== 1'b0) begin
          mism++;
          if (bad_s < 0) begin bad_s = s; bad_c = c; bad_a = line_pull; bad_e = (c < len); end
        end
        if (sv) slen = (s == NSYM - 1) ? slv[10] : slv[s-P-9];
        slave_pull = sv && c >= 2 && c < slen;
        if (poke && s == P + 5 && c == 0) begin
          start = 1'b1; reg_addr = ~ra; slave_addr = ~sa; wdata = ~wd;
        end else start = 1'b0;
        @(negedge clk);
      end
    end
    start = 1'b0; slave_pull = 1'b0;
    total++;
    if (mism != 0) begin
      bad++;
      $display("FAIL R1 R2 R3 R4 %s waveform slot=%0d cycle=%0d actual=%0d expected=%0d",
               tag, bad_s, bad_c, bad_a, bad_e);
    end
    check({"R8 busy low at end ", tag}, busy, 0);
    check({"R8 done pulse ", tag}, done, 1);
    check({"R7 ack ", tag}, ack_fail, klass(slv[10]) != 1);
    if (rd) begin
      for (int i = 0; i < 8; i++) exp_rd[7-i] = (klass(slv[i]) == 2);
      exp_p2 = (klass(slv[8]) == 2);
      check({"R5 R6 rdata ", tag}, rdata, exp_rd);
      check({"R6 parity ", tag}, parity_err, ^{exp_rd, exp_p2});
      last_rdata = exp_rd;
    end else begin
      check({"R6 write clears parity ", tag}, parity_err, 0);
      check({"R6 write keeps rdata ", tag}, rdata, last_rdata);
    end
    @(negedge clk);
    check({"R8 done one cycle ", tag}, done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 busy", busy, 0);
    check("R10 done", done, 0);
    check("R10 line_pull", line_pull, 0);
    check("R10 rdata", rdata, 0);
    check("R10 parity_err", parity_err, 0);
    check("R10 ack_fail", ack_fail, 0);

    set_byte(8'h00, 0, 3 * U);
    run_frame(3'd5, 4'b1010, 8'hA5, 0, "write ok");
    set_byte(8'h00, 0, 6 * U);
    run_frame(3'd2, 4'b1111, 8'h3C, 0, "write nak");

    set_byte(8'h96, 0, 3 * U);
    run_frame(3'd3, 4'b0110, 8'h00, 0, "read ok");
    set_byte(8'h5B, 0, 3 * U);
    run_frame(3'd1, 4'b0001, 8'h00, 0, "read bad parity");

    set_byte(8'h00, 0, 0);
    slv[0] = 2 * U - 1; slv[1] = 2 * U; slv[2] = 9 * U / 2; slv[3] = 9 * U / 2 + 1;
    slv[4] = 6 * U; slv[5] = 0; slv[6] = 9 * U; slv[7] = 3 * U;
    run_frame(3'd7, 4'b0000, 8'h00, 0, "read thresholds ack sync");

    set_byte(8'hFF, 0, 3 * U);
    run_frame(3'd6, 4'b1001, 8'hC3, 1, "R9 write start while busy");
    run_frame(3'd0, 4'b1000, 8'h00, 0, "write after read");

    check("R8 idle after frames", busy, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule